// File: doc/BRIEF.md
# Four-Cache Snooping Coherence Controller with a Forward State

This block keeps the line states of four private caches coherent over one atomic snooping bus. Each cache line is held in one of five states: Invalid, Shared, Exclusive, Forward or Modified. Forward marks the single clean copy that answers shared reads. When a Forward holder exists, the other sharers and the memory stay silent. No state allows a line to be both dirty and shared. A dirty line that is read by another core hands its data to the reader, writes it back to memory in the same transaction, and becomes the clean Forward copy.

Each core presents read, write and evict requests with an address and write data, and holds the request until it sees its done pulse. A round-robin arbiter grants one request per cycle. The granted transaction resolves in that cycle: the requester's lookup, the snoop of the three other caches, the choice of data supplier, every state change and any memory update all happen together. The done pulse, the returned data and a record of the bus transaction (command and supplier) appear one cycle after the grant. A behavioural backing memory answers whenever no cache is the supplier. A probe port shows the state of one line in all four caches.

Top module: `mesif_fwd_ctrl`

## Requirements
- R1: After reset every line of every cache is Invalid (state code 0; codes are I=0, S=1, E=2, F=3, M=4), no done pulse is raised, and memory line a holds MEM_BASE + a.
- R2: A read (op code 0) that misses and finds no copy in any other cache issues a shared read (bus command 1). Memory supplies the data, and the requester enters Exclusive.
- R3: On a read miss where another cache holds the line Exclusive, that cache supplies the data and moves to Forward. The requester enters Shared.
- R4: A Forward holder supplies the data for every later read miss and stays in Forward. The new reader enters Shared. Shared caches and memory supply nothing.
- R5: On a read miss where another cache holds the line Modified, that cache supplies the data and becomes Forward, and memory is updated with the data in the same transaction. The requester enters Shared.
- R6: A write (op code 1) from a Shared or Forward holder issues an exclusive read (bus command 2) with no data supplier. Every other copy goes to Invalid, and the writer enters Modified holding the write data.
- R7: A write miss issues an exclusive read. The data supplier is chosen in priority order: a Modified holder, then a Forward holder, then an Exclusive holder, then memory. All other copies become Invalid, and the writer enters Modified. A write to an Exclusive line moves it to Modified without any bus command (command 0).
- R8: An evict (op code 2) of a clean line (Exclusive, Shared or Forward) drops it to Invalid with no bus command. After a Forward copy is dropped, memory answers the next read miss, and the reader enters Shared if other sharers remain.
- R9: An evict of a Modified line issues a write-back (bus command 3) that updates memory. The line becomes Invalid, and no supplier is flagged.
- R10: Every shared or exclusive read that needs data has exactly one supplier, flagged as either memory or a one-hot cache. Each line has at most one Forward copy. A Modified or Exclusive copy never coexists with another valid copy.
- R11: Requests are granted round-robin, starting after the last core granted, one per cycle. The done pulse for a request is high for exactly one cycle, one cycle after its grant, and never for two cores at once.
- R12: A read hit returns the cached data with no bus command, no supplier and no state change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | NCORE | Request pending, one bit per core, held until done |
| req_op | input | 2*NCORE | Request op per core: 0 read, 1 write, 2 evict |
| req_addr | input | AW*NCORE | Line address per core |
| req_wdata | input | DW*NCORE | Write data per core |
| rsp_done | output | NCORE | One-cycle completion pulse per core |
| rsp_data | output | DW | Line data for the completed read, or write data for a write |
| bus_cmd | output | 2 | Bus command of the completed request: 0 none, 1 shared read, 2 exclusive read, 3 write-back |
| bus_src_mem | output | 1 | Memory supplied the data |
| bus_src_cache | output | NCORE | One-hot cache that supplied the data |
| probe_addr | input | AW | Line selected for the state view |
| probe_state | output | 3*NCORE | State code of the probed line in each cache |

## Verification
On every cycle, the assertions check the coherence invariants for every line: a single Forward copy, and no Modified or Exclusive copy alongside any other valid copy. They also check the supplier rule (never more than one supplier, exactly one on a shared read, none on a write-back) and the done-pulse discipline. Only the bench scenarios can show that the right agent answered and the right states followed for each case: the Exclusive-to-Forward hand-off, a repeated Forward response, a dirty hand-off whose write-back is later served by memory, priority on a write miss, silent upgrades and drops, and the rotating grant order under four simultaneous requests.

// File: rtl/mesif_pkg.sv
// Package: shared encodings for the forwarding coherence controller.
// Assumes: state, op and bus codes are visible at the ports and must not change.
package mesif_pkg;
    localparam logic [2:0] ST_I = 3'd0;
    localparam logic [2:0] ST_S = 3'd1;
    localparam logic [2:0] ST_E = 3'd2;
    localparam logic [2:0] ST_F = 3'd3;
    localparam logic [2:0] ST_M = 3'd4;

    localparam logic [1:0] OP_RD = 2'd0;
    localparam logic [1:0] OP_WR = 2'd1;
    localparam logic [1:0] OP_EV = 2'd2;

    localparam logic [1:0] BUS_IDLE = 2'd0;
    localparam logic [1:0] BUS_RDS  = 2'd1;
    localparam logic [1:0] BUS_RDX  = 2'd2;
    localparam logic [1:0] BUS_WB   = 2'd3;

    // Supplier priority ranks used when snooping the other caches
    localparam int PRI_NONE = 0;
    localparam int PRI_E    = 1;
    localparam int PRI_F    = 2;
    localparam int PRI_M    = 3;
endpackage

// File: rtl/mesif_rr_arbiter.sv
// Module: round-robin arbiter granting one requester per cycle.
// Assumes: N >= 2; the search starts at the core after the last grant.
module mesif_rr_arbiter #(
    parameter int N = 4,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    output logic          gnt_v,
    output logic [IW-1:0] gnt_idx
);
    logic [IW-1:0] ptr_q;

    // Pick the first requester at or after the rotating pointer
    always_comb begin
        int j;
        gnt_v   = 1'b0;
        gnt_idx = '0;
        j       = 0;
        for (int off = 0; off < N; off++) begin
            j = (int'(ptr_q) + off) % N;
            if (!gnt_v && req[j]) begin
                gnt_v   = 1'b1;
                gnt_idx = IW'(j);
            end
        end
    end

    // Move the pointer past the core just granted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (gnt_v) begin
            ptr_q <= (gnt_idx == IW'(N - 1)) ? '0 : gnt_idx + 1'b1;
        end
    end
endmodule

// File: rtl/mesif_line_store.sv
// Module: per-cache storage of line states and line data.
// Assumes: one state write and one data write per cycle, both at acc_addr;
// LINES is a power of two.
module mesif_line_store
    import mesif_pkg::*;
#(
    parameter int LINES = 8,
    parameter int DW    = 16,
    localparam int AW   = $clog2(LINES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [AW-1:0]      acc_addr,
    input  logic               st_we,
    input  logic [2:0]         st_nx,
    input  logic               dat_we,
    input  logic [DW-1:0]      dat_nx,
    output logic [2:0]         acc_st,
    output logic [DW-1:0]      acc_dat,
    input  logic [AW-1:0]      prb_addr,
    output logic [2:0]         prb_st,
    output logic [LINES*3-1:0] st_flat
);
    logic [2:0]    st_q  [LINES];
    logic [DW-1:0] dat_q [LINES];

    // Hold state and data; reset leaves every line Invalid
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) begin
                st_q[i]  <= ST_I;
                dat_q[i] <= '0;
            end
        end else begin
            if (st_we)  st_q[acc_addr]  <= st_nx;
            if (dat_we) dat_q[acc_addr] <= dat_nx;
        end
    end

    // Read ports for the transaction and the probe
    assign acc_st  = st_q[acc_addr];
    assign acc_dat = dat_q[acc_addr];
    assign prb_st  = st_q[prb_addr];

    // Flatten all states for the invariant checker
    always_comb begin
        for (int i = 0; i < LINES; i++) st_flat[i*3 +: 3] = st_q[i];
    end
endmodule

// File: rtl/mesif_backing_mem.sv
// Module: behavioural backing memory, one word per line.
// Assumes: reset loads line a with BASE + a; one write per cycle.
module mesif_backing_mem #(
    parameter int LINES         = 8,
    parameter int DW            = 16,
    parameter logic [DW-1:0] BASE = '0,
    localparam int AW           = $clog2(LINES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          we,
    input  logic [DW-1:0] wd,
    output logic [DW-1:0] rd
);
    logic [DW-1:0] mem_q [LINES];

    // Store write-backs; reset fills a known pattern
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) mem_q[i] <= BASE + DW'(i);
        end else if (we) begin
            mem_q[addr] <= wd;
        end
    end

    assign rd = mem_q[addr];
endmodule

// File: rtl/mesif_snoop_resolver.sv
// Module: resolves one granted transaction in a single cycle: snoops the other
// caches, selects the one data supplier, and computes every state, data and
// memory update.
// Assumes: the inputs hold a consistent set of states (at most one F, M/E alone).
module mesif_snoop_resolver
    import mesif_pkg::*;
#(
    parameter int NCORE = 4,
    parameter int DW    = 16,
    localparam int IW   = $clog2(NCORE)
) (
    input  logic                act,
    input  logic [IW-1:0]       gidx,
    input  logic [1:0]          op,
    input  logic [DW-1:0]       wdata,
    input  logic [NCORE*3-1:0]  st_at,
    input  logic [NCORE*DW-1:0] dat_at,
    input  logic [DW-1:0]       mem_at,
    output logic [NCORE-1:0]    st_we,
    output logic [NCORE*3-1:0]  st_nx,
    output logic [NCORE-1:0]    dat_we,
    output logic [DW-1:0]       dat_nx,
    output logic                mem_we,
    output logic [DW-1:0]       mem_wd,
    output logic [1:0]          cmd,
    output logic                src_mem,
    output logic [NCORE-1:0]    src_cache,
    output logic [DW-1:0]       rdata
);
    // Decide the bus action and next states for the granted request
    always_comb begin
        int            gi;
        int            sup_pri;
        int            sup_idx;
        logic          oth_valid;
        logic [2:0]    own_st;
        logic [DW-1:0] own_dat;
        logic [DW-1:0] sup_dat;
        logic [2:0]    cst;

        gi        = int'(gidx);
        own_st    = st_at[gi*3 +: 3];
        own_dat   = dat_at[gi*DW +: DW];
        sup_pri   = PRI_NONE;
        sup_idx   = 0;
        oth_valid = 1'b0;
        cst       = ST_I;

        // Rank the other caches as candidate suppliers: M over F over E
        for (int k = 0; k < NCORE; k++) begin
            if (k != gi) begin
                cst = st_at[k*3 +: 3];
                if (cst != ST_I) oth_valid = 1'b1;
                if (cst == ST_M && sup_pri < PRI_M) begin
                    sup_pri = PRI_M;
                    sup_idx = k;
                end else if (cst == ST_F && sup_pri < PRI_F) begin
                    sup_pri = PRI_F;
                    sup_idx = k;
                end else if (cst == ST_E && sup_pri < PRI_E) begin
                    sup_pri = PRI_E;
                    sup_idx = k;
                end
            end
        end
        sup_dat = (sup_pri == PRI_NONE) ? mem_at : dat_at[sup_idx*DW +: DW];

        st_we     = '0;
        st_nx     = st_at;
        dat_we    = '0;
        dat_nx    = wdata;
        mem_we    = 1'b0;
        mem_wd    = own_dat;
        cmd       = BUS_IDLE;
        src_mem   = 1'b0;
        src_cache = '0;
        rdata     = '0;

        if (act) begin
            case (op)
                OP_RD: begin
                    if (own_st != ST_I) begin
                        rdata = own_dat;
                    end else begin
                        cmd          = BUS_RDS;
                        rdata        = sup_dat;
                        dat_nx       = sup_dat;
                        dat_we[gi]   = 1'b1;
                        st_we[gi]    = 1'b1;
                        st_nx[gi*3 +: 3] = (sup_pri == PRI_NONE && !oth_valid) ? ST_E : ST_S;
                        if (sup_pri == PRI_NONE) begin
                            src_mem = 1'b1;
                        end else begin
                            src_cache[sup_idx]    = 1'b1;
                            st_we[sup_idx]        = 1'b1;
                            st_nx[sup_idx*3 +: 3] = ST_F;
                            if (sup_pri == PRI_M) begin
                                mem_we = 1'b1;
                                mem_wd = sup_dat;
                            end
                        end
                    end
                end
                OP_WR: begin
                    rdata            = wdata;
                    dat_we[gi]       = 1'b1;
                    st_we[gi]        = 1'b1;
                    st_nx[gi*3 +: 3] = ST_M;
                    if (own_st == ST_S || own_st == ST_F || own_st == ST_I) begin
                        cmd = BUS_RDX;
                        if (own_st == ST_I) begin
                            if (sup_pri == PRI_NONE) src_mem = 1'b1;
                            else                     src_cache[sup_idx] = 1'b1;
                        end
                        for (int k = 0; k < NCORE; k++) begin
                            if (k != gi && st_at[k*3 +: 3] != ST_I) begin
                                st_we[k]        = 1'b1;
                                st_nx[k*3 +: 3] = ST_I;
                            end
                        end
                    end
                end
                OP_EV: begin
                    if (own_st != ST_I) begin
                        st_we[gi]        = 1'b1;
                        st_nx[gi*3 +: 3] = ST_I;
                    end
                    if (own_st == ST_M) begin
                        cmd    = BUS_WB;
                        mem_we = 1'b1;
                        mem_wd = own_dat;
                    end
                end
                default: begin
                end
            endcase
        end
    end
endmodule

// File: rtl/mesif_fwd_ctrl.sv
// Module: top of the forwarding coherence controller for NCORE private caches
// on one atomic snooping bus. One request is granted and resolved per cycle;
// its done pulse, data and bus record follow one cycle later.
// Assumes: each core holds its request stable until it sees its done pulse.
module mesif_fwd_ctrl
    import mesif_pkg::*;
#(
    parameter int NCORE             = 4,
    parameter int LINES             = 8,
    parameter int DW                = 16,
    parameter logic [DW-1:0] MEM_BASE = 16'hA000,
    localparam int AW               = $clog2(LINES),
    localparam int IW               = $clog2(NCORE)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NCORE-1:0]    req_valid,
    input  logic [NCORE*2-1:0]  req_op,
    input  logic [NCORE*AW-1:0] req_addr,
    input  logic [NCORE*DW-1:0] req_wdata,
    output logic [NCORE-1:0]    rsp_done,
    output logic [DW-1:0]       rsp_data,
    output logic [1:0]          bus_cmd,
    output logic                bus_src_mem,
    output logic [NCORE-1:0]    bus_src_cache,
    input  logic [AW-1:0]       probe_addr,
    output logic [NCORE*3-1:0]  probe_state
);
    logic [NCORE-1:0]       done_q;
    logic [NCORE-1:0]       req_eff;
    logic                   gnt_v;
    logic [IW-1:0]          gnt_idx;
    logic [1:0]             g_op;
    logic [AW-1:0]          g_addr;
    logic [DW-1:0]          g_wdata;
    logic [NCORE*3-1:0]     st_at;
    logic [NCORE*DW-1:0]    dat_at;
    logic [NCORE-1:0]       st_we;
    logic [NCORE*3-1:0]     st_nx;
    logic [NCORE-1:0]       dat_we;
    logic [DW-1:0]          dat_nx;
    logic                   mem_we;
    logic [DW-1:0]          mem_wd;
    logic [DW-1:0]          mem_rd;
    logic [1:0]             r_cmd;
    logic                   r_src_mem;
    logic [NCORE-1:0]       r_src_cache;
    logic [DW-1:0]          r_data;
    logic [NCORE*LINES*3-1:0] all_states;

    // A core just completing is masked so its held request is not regranted
    assign req_eff = req_valid & ~done_q;

    mesif_rr_arbiter #(.N(NCORE)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req_eff),
        .gnt_v   (gnt_v),
        .gnt_idx (gnt_idx)
    );

    // Route the granted core's request fields onto the bus
    always_comb begin
        g_op    = req_op[0 +: 2];
        g_addr  = req_addr[0 +: AW];
        g_wdata = req_wdata[0 +: DW];
        for (int c = 0; c < NCORE; c++) begin
            if (IW'(c) == gnt_idx) begin
                g_op    = req_op[c*2 +: 2];
                g_addr  = req_addr[c*AW +: AW];
                g_wdata = req_wdata[c*DW +: DW];
            end
        end
    end

    for (genvar c = 0; c < NCORE; c++) begin : g_cache
        mesif_line_store #(.LINES(LINES), .DW(DW)) u_store (
            .clk      (clk),
            .rst_n    (rst_n),
            .acc_addr (g_addr),
            .st_we    (st_we[c]),
            .st_nx    (st_nx[c*3 +: 3]),
            .dat_we   (dat_we[c]),
            .dat_nx   (dat_nx),
            .acc_st   (st_at[c*3 +: 3]),
            .acc_dat  (dat_at[c*DW +: DW]),
            .prb_addr (probe_addr),
            .prb_st   (probe_state[c*3 +: 3]),
            .st_flat  (all_states[c*LINES*3 +: LINES*3])
        );
    end

    mesif_backing_mem #(.LINES(LINES), .DW(DW), .BASE(MEM_BASE)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (g_addr),
        .we    (mem_we),
        .wd    (mem_wd),
        .rd    (mem_rd)
    );

    mesif_snoop_resolver #(.NCORE(NCORE), .DW(DW)) u_res (
        .act       (gnt_v),
        .gidx      (gnt_idx),
        .op        (g_op),
        .wdata     (g_wdata),
        .st_at     (st_at),
        .dat_at    (dat_at),
        .mem_at    (mem_rd),
        .st_we     (st_we),
        .st_nx     (st_nx),
        .dat_we    (dat_we),
        .dat_nx    (dat_nx),
        .mem_we    (mem_we),
        .mem_wd    (mem_wd),
        .cmd       (r_cmd),
        .src_mem   (r_src_mem),
        .src_cache (r_src_cache),
        .rdata     (r_data)
    );

    // Register the completion record one cycle after the grant
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q        <= '0;
            rsp_data      <= '0;
            bus_cmd       <= BUS_IDLE;
            bus_src_mem   <= 1'b0;
            bus_src_cache <= '0;
        end else begin
            done_q <= '0;
            if (gnt_v) done_q[gnt_idx] <= 1'b1;
            rsp_data      <= gnt_v ? r_data : '0;
            bus_cmd       <= r_cmd;
            bus_src_mem   <= r_src_mem;
            bus_src_cache <= r_src_cache;
        end
    end

    assign rsp_done = done_q;
endmodule

// File: rtl/mesif_fwd_checker.sv
// Module: invariant checker bound to the coherence controller top.
// Assumes: line_states packs core c, line l at bits ((c*LINES)+l)*3.
module mesif_fwd_checker
    import mesif_pkg::*;
#(
    parameter int NCORE = 4,
    parameter int LINES = 8,
    localparam int CW   = $clog2(NCORE + 1)
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [NCORE-1:0]         req_valid,
    input logic [NCORE-1:0]         rsp_done,
    input logic [1:0]               bus_cmd,
    input logic                     bus_src_mem,
    input logic [NCORE-1:0]         bus_src_cache,
    input logic [NCORE*LINES*3-1:0] line_states
);
    for (genvar l = 0; l < LINES; l++) begin : g_line
        logic [CW-1:0] n_f;
        logic [CW-1:0] n_v;
        logic [CW-1:0] n_x;

        // Count Forward, valid and exclusive-class copies of this line
        always_comb begin
            logic [2:0] s;
            n_f = '0;
            n_v = '0;
            n_x = '0;
            for (int c = 0; c < NCORE; c++) begin
                s = line_states[(c*LINES + l)*3 +: 3];
                if (s == ST_F) n_f = n_f + CW'(1);
                if (s != ST_I) n_v = n_v + CW'(1);
                if (s == ST_M || s == ST_E) n_x = n_x + CW'(1);
            end
        end

        assert_single_fwd_R10: assert property (@(posedge clk) disable iff (!rst_n)
            n_f <= CW'(1));
        assert_excl_alone_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (n_x != '0) |-> (n_v == CW'(1)));
    end

    assert_one_supplier_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bus_src_mem, bus_src_cache}));
    assert_rds_supplied_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd == BUS_RDS) |-> ($countones({bus_src_mem, bus_src_cache}) == 1));
    assert_wb_no_supplier_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd == BUS_WB) |-> ({bus_src_mem, bus_src_cache} == '0));
    assert_done_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rsp_done));
    assert_cmd_has_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd != BUS_IDLE) |-> (rsp_done != '0));

    for (genvar c = 0; c < NCORE; c++) begin : g_core
        assert_done_after_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
            rsp_done[c] |-> $past(req_valid[c]));
    end
endmodule

bind mesif_fwd_ctrl mesif_fwd_checker #(.NCORE(NCORE), .LINES(LINES)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .rsp_done      (rsp_done),
    .bus_cmd       (bus_cmd),
    .bus_src_mem   (bus_src_mem),
    .bus_src_cache (bus_src_cache),
    .line_states   (all_states)
);

// File: tb/mesif_fwd_ctrl_bench.sv
`timescale 1ns/1ps
// Directed bench for the forwarding coherence controller.
module mesif_fwd_ctrl_bench;
    localparam int NCORE = 4;
    localparam int LINES = 8;
    localparam int DW    = 16;
    localparam int AW    = 3;
    localparam int MB    = 'hA000;
    localparam int SRC_MEM = 16;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [NCORE-1:0]    req_valid = '0;
    logic [NCORE*2-1:0]  req_op = '0;
    logic [NCORE*AW-1:0] req_addr = '0;
    logic [NCORE*DW-1:0] req_wdata = '0;
    logic [NCORE-1:0]    rsp_done;
    logic [DW-1:0]       rsp_data;
    logic [1:0]          bus_cmd;
    logic                bus_src_mem;
    logic [NCORE-1:0]    bus_src_cache;
    logic [AW-1:0]       probe_addr = '0;
    logic [NCORE*3-1:0]  probe_state;

    int  total = 0;
    int  bad = 0;
    bit  finished = 1'b0;

    always #2.5 clk = ~clk;

    mesif_fwd_ctrl u_mesif_fwd_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_op        (req_op),
        .req_addr      (req_addr),
        .req_wdata     (req_wdata),
        .rsp_done      (rsp_done),
        .rsp_data      (rsp_data),
        .bus_cmd       (bus_cmd),
        .bus_src_mem   (bus_src_mem),
        .bus_src_cache (bus_src_cache),
        .probe_addr    (probe_addr),
        .probe_state   (probe_state)
    );

    task automatic chk(input string tag, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    task automatic st_chk(input string tag, input int c, input int a, input int exp);
        probe_addr = AW'(a);
        #0.1;
        chk(tag, int'(probe_state[c*3 +: 3]), exp);
    endtask

    // Issue one request and check the completion record
    task automatic op_chk(input string tag, input int c, input int op, input int a,
                          input int wd, input int e_cmd, input int e_src, input int e_data);
        int n;
        @(negedge clk);
        req_op[c*2 +: 2]     = 2'(op);
        req_addr[c*AW +: AW] = AW'(a);
        req_wdata[c*DW +: DW] = DW'(wd);
        req_valid[c]         = 1'b1;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!rsp_done[c] && n < 50);
        chk({tag, " done"}, int'(rsp_done[c]), 1);
        chk({tag, " cmd"}, int'(bus_cmd), e_cmd);
        chk({tag, " src"}, int'({bus_src_mem, bus_src_cache}), e_src);
        chk({tag, " data"}, int'(rsp_data), e_data);
        req_valid[c] = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 no done after reset", int'(rsp_done), 0);
        for (int c = 0; c < NCORE; c++) begin
            st_chk("R1 line0 invalid", c, 0, 0);
            st_chk("R1 line7 invalid", c, 7, 0);
        end
    endtask

    task automatic t_exclusive_fill;
        op_chk("R2 cold read", 0, 0, 1, 0, 1, SRC_MEM, MB + 1);
        st_chk("R2 requester E", 0, 1, 2);
    endtask

    task automatic t_forward_handoff;
        op_chk("R3 read of E line", 1, 0, 1, 0, 1, 1, MB + 1);
        st_chk("R3 holder to F", 0, 1, 3);
        st_chk("R3 reader S", 1, 1, 1);
        op_chk("R4 F answers again", 2, 0, 1, 0, 1, 1, MB + 1);
        st_chk("R4 F stays", 0, 1, 3);
        st_chk("R4 reader S", 2, 1, 1);
        st_chk("R4 old sharer S", 1, 1, 1);
        op_chk("R12 read hit", 1, 0, 1, 0, 0, 0, MB + 1);
        st_chk("R12 state unchanged", 1, 1, 1);
    endtask

    task automatic t_upgrade_and_dirty_read;
        op_chk("R6 F holder writes", 0, 1, 1, 'h1234, 2, 0, 'h1234);
        st_chk("R6 writer M", 0, 1, 4);
        st_chk("R6 sharer1 I", 1, 1, 0);
        st_chk("R6 sharer2 I", 2, 1, 0);
        op_chk("R5 read of M line", 3, 0, 1, 0, 1, 1, 'h1234);
        st_chk("R5 M holder to F", 0, 1, 3);
        st_chk("R5 reader S", 3, 1, 1);
        op_chk("R8 evict F silent", 0, 2, 1, 0, 0, 0, 0);
        st_chk("R8 evicted I", 0, 1, 0);
        op_chk("R8 R5 memory answers after F drop", 1, 0, 1, 0, 1, SRC_MEM, 'h1234);
        st_chk("R8 reader S with sharer", 1, 1, 1);
    endtask

    task automatic t_write_miss;
        op_chk("R7 write miss from memory", 2, 1, 1, 'h5555, 2, SRC_MEM, 'h5555);
        st_chk("R7 writer M", 2, 1, 4);
        st_chk("R7 sharer1 I", 1, 1, 0);
        st_chk("R7 sharer3 I", 3, 1, 0);
        op_chk("R7 write miss M supplies", 0, 1, 1, 'h6666, 2, 4, 'h6666);
        st_chk("R7 new writer M", 0, 1, 4);
        st_chk("R7 old M I", 2, 1, 0);
        op_chk("R7 fill E", 1, 0, 2, 0, 1, SRC_MEM, MB + 2);
        op_chk("R7 silent E write", 1, 1, 2, 'h7777, 0, 0, 'h7777);
        st_chk("R7 E to M", 1, 2, 4);
    endtask

    task automatic t_writeback;
        op_chk("R9 evict M", 1, 2, 2, 0, 3, 0, 0);
        st_chk("R9 evicted I", 1, 2, 0);
        op_chk("R9 memory holds written data", 3, 0, 2, 0, 1, SRC_MEM, 'h7777);
        st_chk("R9 reader E", 3, 2, 2);
    endtask

    // All cores request together; pointer sits after core 1
    task automatic t_round_robin;
        int order [4];
        int srcs  [4];
        int cyc   [4];
        int k;
        op_chk("R11 setup", 1, 0, 5, 0, 1, SRC_MEM, MB + 5);
        @(negedge clk);
        for (int c = 0; c < NCORE; c++) begin
            req_op[c*2 +: 2]     = 2'd0;
            req_addr[c*AW +: AW] = AW'(4);
            req_valid[c]         = 1'b1;
        end
        k = 0;
        for (int t = 0; t < 8 && k < 4; t++) begin
            @(negedge clk);
            if (rsp_done != '0) begin
                chk("R11 single done", $countones(rsp_done), 1);
                for (int c = 0; c < NCORE; c++) begin
                    if (rsp_done[c] && k < 4) begin
                        order[k] = c;
                        srcs[k]  = int'({bus_src_mem, bus_src_cache});
                        cyc[k]   = t;
                        req_valid[c] = 1'b0;
                        k++;
                    end
                end
            end
        end
        chk("R11 grants seen", k, 4);
        chk("R11 first core2", order[0], 2);
        chk("R11 second core3", order[1], 3);
        chk("R11 third core0", order[2], 0);
        chk("R11 fourth core1", order[3], 1);
        chk("R11 back to back", cyc[3] - cyc[0], 3);
        chk("R2 first from memory", srcs[0], SRC_MEM);
        chk("R3 second from E holder", srcs[1], 4);
        chk("R4 third from F", srcs[2], 4);
        chk("R4 fourth from F", srcs[3], 4);
        st_chk("R10 single F", 2, 4, 3);
        st_chk("R10 sharer", 0, 4, 1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_exclusive_fill();
        t_forward_handoff();
        t_upgrade_and_dirty_read();
        t_write_miss();
        t_writeback();
        t_round_robin();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule